// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog counter. Its configuration (run enable, count source, timeout exponent) sits in a control register that software can change only through a two-step keyed write. The first write carries the arming key and the intended settings. The next write must carry the firing key and exactly the same settings. Any other write breaks the sequence and leaves the register as it was. While the block is enabled, its counter advances once for each tick of the selected source. Software restarts the count with a clear pulse. If the count reaches 2^psel, the block raises a one-cycle reset request. An early-warning interrupt is raised at the halfway point.

A request also performs the block's own watchdog reset. The counter and key sequence go back to idle. The enable reloads from the auto-start fuse, and the timeout exponent goes back to its default. A sticky cause flag records that the watchdog fired. The source selection survives this reset, but it returns to the internal RC source on an ordinary reset. A debug-halt input freezes the count only when the per-block freeze enable is also set. A stopped source is not detected: the count simply stops.

Top module: `wdog_keyed`

## Requirements
- R1: On the synchronous active-low reset, enable takes the value of `fuse_auto_i`, source becomes 0 (internal RC), psel becomes DEF_PSEL (4), count becomes 0, the cause flag becomes 0, and `irq_o` and `rst_req_o` are low.
- R2: Write data holds the key in bits [31:24], enable in bit 0, source in bit 1 and psel in bits [12:8]. A write with key 0x55 followed by a next write with key 0xAA updates the configuration on the clock edge of the second write. The first write alone changes nothing.
- R3: If the 0xAA write carries any non-key bit different from the preceding 0x55 write, the update is discarded and the configuration is unchanged.
- R4: A write whose key is neither 0x55 nor 0xAA, and a 0xAA write not directly preceded by a 0x55 write, leave the configuration unchanged and return the sequence to idle. A later 0xAA write therefore also fails.
- R5: When enabled, the count rises by one on each tick of the selected source: `tick_rc_i` when source is 0, `tick_lf_i` when source is 1. Ticks of the unselected source, and all ticks while disabled, leave the count unchanged.
- R6: The tick that brings the count to 2^psel produces a `rst_req_o` pulse one cycle wide in the following cycle, and the count restarts at 0.
- R7: The tick that brings the count to 2^(psel-1), for psel of at least 1, produces a one-cycle `irq_o` pulse in the following cycle.
- R8: A `clr_i` pulse sets the count to 0 on the next edge and leaves the configuration unchanged.
- R9: The count holds its value while both `dbg_halt_i` and `dbg_freeze_en_i` are high. With `dbg_halt_i` high alone, counting continues.
- R10: On a watchdog request, the cause flag sets and stays set until the next ordinary reset. Enable reloads from `fuse_auto_i`, psel returns to DEF_PSEL, and source keeps its value.
- R11: A committed update that changes enable or source clears the count. An update that changes only psel keeps the count.
- R12: With no ticks on the selected source, the count holds and no request or interrupt is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low ordinary reset |
| fuse_auto_i | input | 1 | Auto-start fuse, loaded into enable on any reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 32 | Write data: key [31:24], psel [12:8], source [1], enable [0] |
| clr_i | input | 1 | Restart the count |
| tick_rc_i | input | 1 | Count enable from the internal RC source |
| tick_lf_i | input | 1 | Count enable from the low-frequency source |
| dbg_halt_i | input | 1 | Core halted in debug |
| dbg_freeze_en_i | input | 1 | Freeze-in-debug enable for this block |
| cfg_en_o | output | 1 | Current enable |
| cfg_src_o | output | 1 | Current source select |
| cfg_psel_o | output | 5 | Current timeout exponent |
| cnt_o | output | 32 | Current count |
| irq_o | output | 1 | Early-warning interrupt pulse |
| rst_req_o | output | 1 | Watchdog reset request pulse |
| wd_cause_o | output | 1 | Sticky watchdog reset cause flag |

## Verification
Every result is registered once. A configuration commit, a clear and each counted tick are visible one cycle after the edge that samples the stimulus. The interrupt and reset request pulses appear in that same following cycle and last one cycle. The bench changes inputs on the falling edge and reads outputs on the next falling edge. It records the ordinal of the tick after which each pulse is first seen, so the halfway and full-timeout ticks are compared against exact expected tick numbers.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_ARM = 8'h55;
    localparam logic [KEY_W-1:0] KEY_FIRE = 8'hAA;
    localparam int EN_BIT = 0;
    localparam int SRC_BIT = 1;
    localparam int PSEL_LSB = 8;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_st_e;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
#(
    parameter int PL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [PL_W-1:0]  pl_i,
    output logic             commit_o
);
    typedef struct packed {
        key_st_e          st;
        logic [PL_W-1:0]  held;
    } ks_t;

    ks_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        commit_o = 1'b0;
        if (wr_en_i) begin
            if (key_i == KEY_ARM) begin
                s_d.st   = KS_ARMED;
                s_d.held = pl_i;
            end else if (key_i == KEY_FIRE && s_q.st == KS_ARMED && pl_i == s_q.held) begin
                commit_o = 1'b1;
                s_d.st   = KS_IDLE;
            end else begin
                s_d.st   = KS_IDLE;
            end
        end
        if (flush_i) begin
            s_d.st = KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: KS_IDLE, held: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int PSEL_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     tick_i,
    input  logic                     clear_i,
    input  logic [PSEL_W-1:0]        psel_i,
    output logic [(1<<PSEL_W)-1:0]   cnt_o,
    output logic                     hit_irq_o,
    output logic                     hit_req_o
);
    localparam int CNT_W = 1 << PSEL_W;
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] lim, half, nxt;
    logic             inc;

    always_comb begin
        lim       = EXT_W'(1) << psel_i;
        half      = lim >> 1;
        nxt       = {1'b0, cnt_q} + EXT_W'(1);
        inc       = run_i && tick_i && !clear_i;
        cnt_d     = cnt_q;
        hit_irq_o = 1'b0;
        hit_req_o = 1'b0;
        if (clear_i) begin
            cnt_d = '0;
        end else if (inc) begin
            if (nxt == lim) begin
                cnt_d     = '0;
                hit_req_o = 1'b1;
            end else begin
                cnt_d = nxt[CNT_W-1:0];
            end
            if (psel_i != '0 && nxt == half) begin
                hit_irq_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int PSEL_W   = 5,
    parameter int DEF_PSEL = 4,
    parameter int DATA_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fuse_auto_i,
    input  logic                    wr_en_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    clr_i,
    input  logic                    tick_rc_i,
    input  logic                    tick_lf_i,
    input  logic                    dbg_halt_i,
    input  logic                    dbg_freeze_en_i,
    output logic                    cfg_en_o,
    output logic                    cfg_src_o,
    output logic [PSEL_W-1:0]       cfg_psel_o,
    output logic [(1<<PSEL_W)-1:0]  cnt_o,
    output logic                    irq_o,
    output logic                    rst_req_o,
    output logic                    wd_cause_o
);
    localparam int PL_W = DATA_W - KEY_W;

    typedef struct packed {
        logic              en;
        logic              src;
        logic [PSEL_W-1:0] psel;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic cause;
        logic irq;
        logic req;
    } top_t;

    top_t r_d, r_q;

    logic [PL_W-1:0] pl;
    logic            commit, cfg_chg, hit_irq, hit_req, run, tick_sel;

    assign pl = wr_data_i[PL_W-1:0];

    wdk_keyseq #(.PL_W(PL_W)) u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (hit_req),
        .wr_en_i  (wr_en_i),
        .key_i    (wr_data_i[DATA_W-1 -: KEY_W]),
        .pl_i     (pl),
        .commit_o (commit)
    );

    always_comb begin
        cfg_chg  = commit && (pl[EN_BIT] != r_q.ctl.en || pl[SRC_BIT] != r_q.ctl.src);
        run      = r_q.ctl.en && !(dbg_halt_i && dbg_freeze_en_i);
        tick_sel = r_q.ctl.src ? tick_lf_i : tick_rc_i;
    end

    wdk_counter #(.PSEL_W(PSEL_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick_sel),
        .clear_i   (clr_i || cfg_chg),
        .psel_i    (r_q.ctl.psel),
        .cnt_o     (cnt_o),
        .hit_irq_o (hit_irq),
        .hit_req_o (hit_req)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = hit_irq;
        r_d.req = hit_req;
        if (hit_req) begin
            r_d.ctl.en   = fuse_auto_i;
            r_d.ctl.psel = PSEL_W'(DEF_PSEL);
            r_d.cause    = 1'b1;
        end else if (commit) begin
            r_d.ctl.en   = pl[EN_BIT];
            r_d.ctl.src  = pl[SRC_BIT];
            r_d.ctl.psel = pl[PSEL_LSB +: PSEL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctl.en   <= fuse_auto_i;
            r_q.ctl.src  <= 1'b0;
            r_q.ctl.psel <= PSEL_W'(DEF_PSEL);
            r_q.cause    <= 1'b0;
            r_q.irq      <= 1'b0;
            r_q.req      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_en_o   = r_q.ctl.en;
    assign cfg_src_o  = r_q.ctl.src;
    assign cfg_psel_o = r_q.ctl.psel;
    assign irq_o      = r_q.irq;
    assign rst_req_o  = r_q.req;
    assign wd_cause_o = r_q.cause;
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
    parameter int PSEL_W = 5,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en_i,
    input logic [DATA_W-1:0]      wr_data_i,
    input logic                   clr_i,
    input logic                   tick_rc_i,
    input logic                   tick_lf_i,
    input logic                   dbg_halt_i,
    input logic                   dbg_freeze_en_i,
    input logic                   cfg_en_o,
    input logic                   cfg_src_o,
    input logic [PSEL_W-1:0]      cfg_psel_o,
    input logic [(1<<PSEL_W)-1:0] cnt_o,
    input logic                   irq_o,
    input logic                   rst_req_o,
    input logic                   wd_cause_o
);
    a_r4_nonfire_write_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[DATA_W-1 -: 8] != 8'hAA)
        |=> ($stable({cfg_en_o, cfg_src_o, cfg_psel_o}) || rst_req_o));

    a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    a_r9_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt_i && dbg_freeze_en_i && !clr_i && !wr_en_i) |=> $stable(cnt_o));

    a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cause_o |=> wd_cause_o);

    a_r10_req_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> wd_cause_o);

    a_r10_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (cfg_src_o == $past(cfg_src_o)));

    a_r12_req_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(cfg_src_o ? tick_lf_i : tick_rc_i));
endmodule

bind wdog_keyed wdk_checker #(.PSEL_W(PSEL_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .clr_i           (clr_i),
    .tick_rc_i       (tick_rc_i),
    .tick_lf_i       (tick_lf_i),
    .dbg_halt_i      (dbg_halt_i),
    .dbg_freeze_en_i (dbg_freeze_en_i),
    .cfg_en_o        (cfg_en_o),
    .cfg_src_o       (cfg_src_o),
    .cfg_psel_o      (cfg_psel_o),
    .cnt_o           (cnt_o),
    .irq_o           (irq_o),
    .rst_req_o       (rst_req_o),
    .wd_cause_o      (wd_cause_o)
);

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fuse_auto_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        clr_i = 1'b0;
    logic        tick_rc_i = 1'b0;
    logic        tick_lf_i = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        dbg_freeze_en_i = 1'b0;
    logic        cfg_en_o, cfg_src_o, irq_o, rst_req_o, wd_cause_o;
    logic [4:0]  cfg_psel_o;
    logic [31:0] cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    int irq_at, req_at, irq_n, req_n;

    always #(CLK_P/2) clk = ~clk;

    wdog_keyed u0 (
        .clk(clk), .rst_n(rst_n), .fuse_auto_i(fuse_auto_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .clr_i(clr_i),
        .tick_rc_i(tick_rc_i), .tick_lf_i(tick_lf_i),
        .dbg_halt_i(dbg_halt_i), .dbg_freeze_en_i(dbg_freeze_en_i),
        .cfg_en_o(cfg_en_o), .cfg_src_o(cfg_src_o), .cfg_psel_o(cfg_psel_o),
        .cnt_o(cnt_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .wd_cause_o(wd_cause_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] key, input logic en,
                                       input logic src, input logic [4:0] psel);
        logic [31:0] d;
        d = '0;
        d[31:24] = key;
        d[0] = en;
        d[1] = src;
        d[12:8] = psel;
        return d;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic commit(input logic en, input logic src, input logic [4:0] psel);
        wr(mk(8'h55, en, src, psel));
        wr(mk(8'hAA, en, src, psel));
    endtask

    task automatic ticks(input int n, input bit lf);
        irq_at = 0; req_at = 0; irq_n = 0; req_n = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (lf) tick_lf_i = 1'b1; else tick_rc_i = 1'b1;
            @(negedge clk);
            tick_lf_i = 1'b0;
            tick_rc_i = 1'b0;
            if (irq_o) begin irq_n++; if (irq_at == 0) irq_at = i; end
            if (rst_req_o) begin req_n++; if (req_at == 0) req_at = i; end
        end
    endtask

    task automatic do_reset(input logic fuse);
        @(negedge clk);
        fuse_auto_i = fuse;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 en", cfg_en_o, 0);
        chk("R1 src", cfg_src_o, 0);
        chk("R1 psel", cfg_psel_o, 4);
        chk("R1 cnt", cnt_o, 0);
        chk("R1 cause", wd_cause_o, 0);
        chk("R1 pulses", {irq_o, rst_req_o}, 0);
    endtask

    task automatic t_commit;
        wr(mk(8'h55, 1'b1, 1'b0, 5'd3));
        chk("R2 first write alone", cfg_en_o, 0);
        wr(mk(8'hAA, 1'b1, 1'b0, 5'd3));
        chk("R2 en after pair", cfg_en_o, 1);
        chk("R2 psel after pair", cfg_psel_o, 3);
    endtask

    task automatic t_mismatch;
        wr(mk(8'h55, 1'b1, 1'b0, 5'd5));
        wr(mk(8'hAA, 1'b1, 1'b0, 5'd6));
        chk("R3 mismatch discarded", cfg_psel_o, 3);
    endtask

    task automatic t_broken;
        wr(mk(8'h55, 1'b1, 1'b0, 5'd5));
        wr(mk(8'h00, 1'b1, 1'b0, 5'd5));
        wr(mk(8'hAA, 1'b1, 1'b0, 5'd5));
        chk("R4 plain write breaks sequence", cfg_psel_o, 3);
        wr(mk(8'hAA, 1'b1, 1'b0, 5'd5));
        chk("R4 lone AA ignored", cfg_psel_o, 3);
    endtask

    task automatic t_count_src;
        ticks(3, 1'b1);
        chk("R5 unselected source ignored", cnt_o, 0);
        ticks(3, 1'b0);
        chk("R5 selected source counts", cnt_o, 3);
    endtask

    task automatic t_clear;
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0;
        chk("R8 clear count", cnt_o, 0);
        chk("R8 cfg kept", {cfg_en_o, cfg_psel_o}, {1'b1, 5'd3});
    endtask

    task automatic t_timeout;
        ticks(8, 1'b0);
        chk("R7 irq at half", irq_at, 4);
        chk("R7 irq once", irq_n, 1);
        chk("R6 req at full", req_at, 8);
        chk("R6 count restarted", cnt_o, 0);
        chk("R10 cause set", wd_cause_o, 1);
        chk("R10 en from fuse", cfg_en_o, 0);
        chk("R10 psel default", cfg_psel_o, 4);
    endtask

    task automatic t_wd_src;
        commit(1'b1, 1'b1, 5'd2);
        ticks(4, 1'b1);
        chk("R7 irq psel2", irq_at, 2);
        chk("R6 req psel2", req_at, 4);
        chk("R10 src kept", cfg_src_o, 1);
        chk("R10 cause stays", wd_cause_o, 1);
        do_reset(1'b0);
        chk("R1 src to RC", cfg_src_o, 0);
        chk("R1 cause cleared", wd_cause_o, 0);
    endtask

    task automatic t_commit_clears;
        commit(1'b1, 1'b0, 5'd5);
        ticks(3, 1'b0);
        chk("R5 count 3", cnt_o, 3);
        commit(1'b1, 1'b0, 5'd6);
        chk("R11 psel change keeps count", cnt_o, 3);
        commit(1'b1, 1'b1, 5'd6);
        chk("R11 src change clears", cnt_o, 0);
    endtask

    task automatic t_debug;
        dbg_halt_i = 1'b1;
        ticks(2, 1'b1);
        chk("R9 halt alone counts", cnt_o, 2);
        dbg_freeze_en_i = 1'b1;
        ticks(2, 1'b1);
        chk("R9 frozen", cnt_o, 2);
        dbg_halt_i = 1'b0;
        ticks(1, 1'b1);
        chk("R9 resumes", cnt_o, 3);
        dbg_freeze_en_i = 1'b0;
    endtask

    task automatic t_no_tick;
        ticks(20, 1'b0);
        repeat (100) @(negedge clk);
        chk("R12 count held", cnt_o, 3);
        chk("R12 no pulses", irq_n + req_n, 0);
        chk("R12 cause clear", wd_cause_o, 0);
    endtask

    task automatic t_disabled;
        commit(1'b0, 1'b1, 5'd6);
        ticks(3, 1'b1);
        chk("R5 disabled holds", cnt_o, 0);
    endtask

    task automatic t_fuse;
        do_reset(1'b1);
        chk("R1 fuse enables", cfg_en_o, 1);
        ticks(16, 1'b0);
        chk("R7 irq fuse", irq_at, 8);
        chk("R6 req fuse", req_at, 16);
        chk("R10 fuse reloads en", cfg_en_o, 1);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        t_reset();
        t_commit();
        t_mismatch();
        t_broken();
        t_count_src();
        t_clear();
        t_timeout();
        t_wd_src();
        t_commit_clears();
        t_debug();
        t_no_tick();
        t_disabled();
        t_fuse();
        finish_up();
    end
endmodule